// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a small set of wired interrupt request lines into message-signaled interrupt writes. Each input line owns one redirection entry. The entry sets whether the line is active high or active low, whether it is edge or level triggered, and whether it is masked. It also holds the 8-bit vector carried as message data and the destination and extended destination IDs that are placed into the message address. When an unmasked line becomes active, the block presents one address/data pair on a valid/ready message port.

Software reaches every internal register through an indirect pair on a simple 32-bit register bus. It first writes an index into a select register, then reads or writes the data window, which acts on the register that the index names. A separate end-of-interrupt register takes a line number. For a level-triggered line, that write ends the service period. If the line is still active at that moment, a fresh message follows. When several lines want service together, the lowest-numbered line is sent first.

Top module: `irqMsgRedirector`

## Requirements
- R1: After reset, the select register reads 0, every entry's low word reads 0x0001_0000 (masked, all other fields zero), every high word reads 0, and msgValid is low.
- R2: Bus offset 0x00 is the select register and reads back its last written value. Offset 0x10 is the data window onto the register named by the select value, and a window read returns the value most recently written there. Select values that name no register read as 0.
- R3: Select value 0x01 exposes a read-only version word: bits 7:0 hold VERSION and bits 23:16 hold NUM_LINES-1, which is 6 for seven lines. Window writes to it have no effect.
- R4: The low word of line n sits at select 0x10+2n and the high word at 0x11+2n. In the low word, bit 16 is the mask (1 = disabled), bit 15 selects level triggering, bit 13 selects active-low polarity, and bits 7:0 are the vector. In the high word, bits 31:24 are the destination ID and bits 23:16 are the extended ID.
- R5: An unmasked edge-triggered line sends exactly one message per inactive-to-active transition. The message data is {24'b0, vector}. The address is {MSG_BASE[31:28], extended ID, destination ID, MSG_BASE[11:0]}, which with the default base 0xF000_0000 gives 0xF000_0000 | ext<<20 | dest<<12.
- R6: A line that becomes active while masked sends no message. An edge-triggered line unmasked while still active sends nothing.
- R7: An unmasked level-triggered line sends one message and then sends nothing more until a write of its line number to the end-of-interrupt register at offset 0x40. That write re-sends the message if the line is still active, and sends nothing if the line is inactive.
- R8: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData stay unchanged.
- R9: When several lines request service in the same cycle, the lowest line number is sent first.
- R10: With active-low polarity, a low input level counts as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr (combinational) |
| irqLines | input | NUM_LINES | Wired interrupt inputs |
| msgValid | output | 1 | Message write pending |
| msgReady | input | 1 | Message accepted when high with msgValid |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
The bench builds the block with the default seven lines, VERSION 0x13 and base 0xF000_0000. Seven lines make the last entry sit at select 0x1D, so 0x1E is the first index past the table, and the maximum-entry field reads 6. With the nonzero base nibble and distinct destination and extended IDs, the placement of each ID field in the address can be observed. Holding msgReady low lets the bench watch the message hold, and raising lines 0 and 6 together tests the two ends of the priority order.

// File: rtl/redirPkg.sv
package redirPkg;
  // bus offsets
  localparam logic [7:0] REG_SEL = 8'h00;
  localparam logic [7:0] REG_WIN = 8'h10;
  localparam logic [7:0] REG_EOI = 8'h40;
  // select indices
  localparam logic [7:0] SEL_VERSION    = 8'h01;
  localparam logic [7:0] SEL_ENTRY_BASE = 8'h10;
  // low-word field positions
  localparam int BIT_MASK  = 16;
  localparam int BIT_LEVEL = 15;
  localparam int BIT_POLLO = 13;
  localparam logic [31:0] LOW_RESET = 32'h0001_0000;

  typedef struct packed {
    logic       launch;
    logic [7:0] line;
  } ctrlStrobe_t;
endpackage

// File: rtl/redirControl.sv
module redirControl
  import redirPkg::*;
#(
  parameter int NUM_LINES = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqVec,
  input  logic                 msgReady,
  output logic                 msgValid,
  output ctrlStrobe_t          strobe
);
  logic       busy;
  logic [7:0] pick;

  // lowest set request wins
  always_comb begin
    pick = 8'd0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqVec[i]) pick = 8'(i);
    end
  end

  assign strobe.launch = !busy && (|reqVec);
  assign strobe.line   = pick;
  assign msgValid      = busy;

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (strobe.launch) busy <= 1'b1;
    else if (busy && msgReady) busy <= 1'b0;
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid); // R8
endmodule

// File: rtl/redirDatapath.sv
module redirDatapath
  import redirPkg::*;
#(
  parameter int          NUM_LINES = 7,
  parameter logic [7:0]  VERSION   = 8'h13,
  parameter logic [31:0] MSG_BASE  = 32'hF000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_LINES-1:0] irqLines,
  input  ctrlStrobe_t          strobe,
  output logic [NUM_LINES-1:0] reqVec,
  output logic [31:0]          msgAddr,
  output logic [31:0]          msgData
);
  localparam logic [7:0]  MAX_IDX  = 8'(NUM_LINES - 1);
  localparam logic [7:0]  LAST_SEL = 8'(SEL_ENTRY_BASE + 2 * NUM_LINES - 1);
  localparam logic [31:0] VER_WORD = {8'h00, MAX_IDX, 8'h00, VERSION};

  logic [7:0]  selReg;
  logic [31:0] lowWord  [NUM_LINES];
  logic [31:0] highWord [NUM_LINES];
  logic [NUM_LINES-1:0] prevActive, edgePend, inService;
  logic [NUM_LINES-1:0] maskBit, levelBit, active, rising;
  logic [NUM_LINES-1:0] launchHit, eoiHit, wrLow, wrHigh;

  logic       winHit, winHigh, windowWr, eoiWr;
  logic [7:0] winOff;
  logic [6:0] winLine;
  logic [31:0] winVal;

  assign winHit   = (selReg >= SEL_ENTRY_BASE) && (selReg <= LAST_SEL);
  assign winOff   = selReg - SEL_ENTRY_BASE;
  assign winLine  = winOff[7:1];
  assign winHigh  = winOff[0];
  assign windowWr = busWrEn && (busAddr == REG_WIN);
  assign eoiWr    = busWrEn && (busAddr == REG_EOI);

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    assign maskBit[i]   = lowWord[i][BIT_MASK];
    assign levelBit[i]  = lowWord[i][BIT_LEVEL];
    assign active[i]    = irqLines[i] ^ lowWord[i][BIT_POLLO];
    assign rising[i]    = active[i] && !prevActive[i];
    assign launchHit[i] = strobe.launch && (strobe.line == 8'(i));
    assign eoiHit[i]    = eoiWr && (busWrData == 32'(i));
    assign wrLow[i]     = windowWr && winHit && (winLine == 7'(i)) && !winHigh;
    assign wrHigh[i]    = windowWr && winHit && (winLine == 7'(i)) && winHigh;
    assign reqVec[i]    = !maskBit[i] &&
                          (levelBit[i] ? (active[i] && !inService[i]) : edgePend[i]);

    AST_LAUNCH_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
      launchHit[i] |-> !maskBit[i]); // R6
    AST_LEVEL_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
      launchHit[i] |-> !inService[i]); // R7
    if (i > 0) begin : gPrio
      AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
        launchHit[i] |-> (reqVec[i-1:0] == '0)); // R9
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg     <= '0;
      prevActive <= '0;
      edgePend   <= '0;
      inService  <= '0;
      msgAddr    <= '0;
      msgData    <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        lowWord[i]  <= LOW_RESET;
        highWord[i] <= '0;
      end
    end else begin
      if (busWrEn && (busAddr == REG_SEL)) selReg <= busWrData[7:0];
      prevActive <= active;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wrLow[i])  lowWord[i]  <= busWrData;
        if (wrHigh[i]) highWord[i] <= busWrData;
        // a new edge outranks the clear of a concurrent launch
        if (rising[i] && !maskBit[i] && !levelBit[i]) edgePend[i] <= 1'b1;
        else if (launchHit[i] || maskBit[i])          edgePend[i] <= 1'b0;
        if (launchHit[i] && levelBit[i]) inService[i] <= 1'b1;
        else if (eoiHit[i])              inService[i] <= 1'b0;
        if (launchHit[i]) begin
          msgAddr <= {MSG_BASE[31:28], highWord[i][23:16], highWord[i][31:24], MSG_BASE[11:0]};
          msgData <= {24'h0, lowWord[i][7:0]};
        end
      end
    end
  end

  always_comb begin
    winVal = '0;
    if (selReg == SEL_VERSION) winVal = VER_WORD;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (winHit && (winLine == 7'(i))) winVal = winHigh ? highWord[i] : lowWord[i];
    end
  end

  always_comb begin
    if (busAddr == REG_SEL)      busRdData = {24'h0, selReg};
    else if (busAddr == REG_WIN) busRdData = winVal;
    else                         busRdData = '0;
  end
endmodule

// File: rtl/irqMsgRedirector.sv
module irqMsgRedirector
  import redirPkg::*;
#(
  parameter int          NUM_LINES = 7,
  parameter logic [7:0]  VERSION   = 8'h13,
  parameter logic [31:0] MSG_BASE  = 32'hF000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [31:0]          msgAddr,
  output logic [31:0]          msgData
);
  ctrlStrobe_t          strobe;
  logic [NUM_LINES-1:0] reqVec;

  redirDatapath #(
    .NUM_LINES(NUM_LINES), .VERSION(VERSION), .MSG_BASE(MSG_BASE)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqLines(irqLines), .strobe(strobe), .reqVec(reqVec),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  redirControl #(
    .NUM_LINES(NUM_LINES)
  ) i_control (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .msgReady(msgReady),
    .msgValid(msgValid), .strobe(strobe)
  );

  AST_MSG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> $stable(msgAddr) && $stable(msgData)); // R8
endmodule

// File: tb/test_irqMsgRedirector.sv
`timescale 1ns/1ps
module test_irqMsgRedirector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [6:0]  irqLines = '0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [31:0] msgAddr, msgData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqMsgRedirector i_irqMsgRedirector (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqLines(irqLines),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  // {select, write value, expected readback}
  localparam logic [71:0] REG_VECS [0:7] = '{
    {8'h10, 32'h0001_A5C3, 32'h0001_A5C3},
    {8'h11, 32'h1234_5678, 32'h1234_5678},
    {8'h1C, 32'h0001_00FF, 32'h0001_00FF},
    {8'h1D, 32'hAABB_0000, 32'hAABB_0000},
    {8'h13, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'h01, 32'hFFFF_FFFF, 32'h0006_0013},
    {8'h1E, 32'hDEAD_BEEF, 32'h0000_0000},
    {8'h0F, 32'h0000_1234, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic winRead(input logic [7:0] sel, output logic [31:0] d);
    busWrite(8'h00, {24'h0, sel});
    busRead(8'h10, d);
  endtask

  task automatic progEntry(input int n, input logic [31:0] lo, input logic [31:0] hi);
    busWrite(8'h00, 32'(8'h10 + 2 * n));
    busWrite(8'h10, lo);
    busWrite(8'h00, 32'(8'h11 + 2 * n));
    busWrite(8'h10, hi);
  endtask

  task automatic waitMsg(input logic [31:0] ea, input logic [31:0] ed, input string tag);
    int n = 0;
    while (!msgValid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(msgValid == 1'b1, {tag, " valid"}, 32'(msgValid), 32'd1);
    check(msgAddr == ea, {tag, " addr"}, msgAddr, ea);
    check(msgData == ed, {tag, " data"}, msgData, ed);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic expectQuiet(input int cyc, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (msgValid) seen = 1'b1;
    end
    check(!seen, tag, 32'(seen), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(msgValid == 1'b0, "R1 msgValid after reset", 32'(msgValid), 32'd0);
    busRead(8'h00, rd);
    check(rd == 32'h0, "R1 select after reset", rd, 32'h0);
    winRead(8'h16, rd);
    check(rd == 32'h0001_0000, "R1 line3 low after reset", rd, 32'h0001_0000);
    winRead(8'h17, rd);
    check(rd == 32'h0, "R1 line3 high after reset", rd, 32'h0);

    // R2 R3 R4 register table
    for (int v = 0; v < 8; v++) begin
      logic [7:0]  s;
      logic [31:0] w, e;
      {s, w, e} = REG_VECS[v];
      busWrite(8'h00, {24'h0, s});
      busWrite(8'h10, w);
      busRead(8'h10, rd);
      check(rd == e, $sformatf("R2 R3 R4 window sel 0x%02h", s), rd, e);
    end
    busRead(8'h00, rd);
    check(rd == 32'h0F, "R2 select readback", rd, 32'h0F);
    expectQuiet(4, "R6 masked table writes quiet");

    // R5 edge trigger with address fields, R8 hold
    progEntry(2, 32'h0000_0042, 32'h5A3C_0000);
    @(negedge clk); irqLines[2] = 1'b1;
    repeat (4) @(negedge clk);
    hold = msgAddr;
    check(msgValid == 1'b1, "R8 valid held without ready", 32'(msgValid), 32'd1);
    check(msgAddr == 32'hF3C5_A000, "R8 addr held", msgAddr, hold);
    waitMsg(32'hF3C5_A000, 32'h42, "R5 edge message");
    expectQuiet(10, "R5 one message per edge");
    irqLines[2] = 1'b0;
    expectQuiet(5, "R5 falling edge quiet");
    irqLines[2] = 1'b1;
    waitMsg(32'hF3C5_A000, 32'h42, "R5 second edge");
    irqLines[2] = 1'b0;

    // R6 masked line
    progEntry(4, 32'h0001_0044, 32'h0);
    @(negedge clk); irqLines[4] = 1'b1;
    expectQuiet(6, "R6 masked line quiet");
    busWrite(8'h00, 32'h18);
    busWrite(8'h10, 32'h0000_0044);
    expectQuiet(8, "R6 not remembered after unmask");
    irqLines[4] = 1'b0;

    // R7 level trigger and end of interrupt
    progEntry(1, 32'h0000_8031, 32'h0);
    @(negedge clk); irqLines[1] = 1'b1;
    waitMsg(32'hF000_0000, 32'h31, "R7 level first message");
    expectQuiet(10, "R7 held in service");
    busWrite(8'h40, 32'd1);
    waitMsg(32'hF000_0000, 32'h31, "R7 EOI refire");
    irqLines[1] = 1'b0;
    busWrite(8'h40, 32'd1);
    expectQuiet(8, "R7 EOI inactive quiet");

    // R10 active low
    irqLines[5] = 1'b1;
    progEntry(5, 32'h0000_2055, 32'h0);
    expectQuiet(3, "R10 inactive high quiet");
    irqLines[5] = 1'b0;
    waitMsg(32'hF000_0000, 32'h55, "R10 active-low message");
    irqLines[5] = 1'b1;
    expectQuiet(5, "R10 return high quiet");

    // R9 priority
    progEntry(0, 32'h0000_0010, 32'h0);
    progEntry(6, 32'h0000_0016, 32'h0);
    @(negedge clk); irqLines[0] = 1'b1; irqLines[6] = 1'b1;
    waitMsg(32'hF000_0000, 32'h10, "R9 lowest line first");
    waitMsg(32'hF000_0000, 32'h16, "R9 higher line next");
    expectQuiet(5, "R9 no extra messages");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule